// File: doc/BRIEF.md
# Two-Wire Device Address Front End

This block sits between the two lines of an open-drain two-wire bus and the command engine of a small peripheral. It samples SCL and SDA with the system clock through a synchroniser and a glitch filter. From the filtered lines it finds start and stop conditions and the rising and falling SCL edges. It then shifts bytes in MSB first and decides the acknowledge that is driven on the ninth clock. SDA leaves the block only as an output enable that pulls the line low, so the board or the bench supplies the pull-up.

The first byte after a start is an identity byte. It holds no direction bit: a fixed type code of 0101 sits in the high nibble and must be followed by the value of four strap inputs. When the identity byte matches, each later byte is acknowledged and handed to the command engine with a one-cycle strobe. When the engine asks for a read at the end of an acknowledge slot, the block drives one byte out instead. While the engine reports a nonvolatile write in progress, the block refuses its own identity byte, so the host can poll until the write is done.

Top module: `twi_dev_front`

## Requirements
- R1: During and directly after reset, sda_oe, rx_valid and frame_end are all low.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Until the first start, SCL pulses produce no acknowledge and no strobe.
- R3: The identity byte is acknowledged (SDA held low through the ninth SCL high) only if bits 7..4 are 0101 and bits 3..0 equal strap_addr. On any other value the block stays silent, and it ignores every following byte until the next start.
- R4: If busy is high when the identity byte completes, the byte is not acknowledged even when it matches. With busy low, the same identity byte is acknowledged again.
- R5: After an acknowledged identity byte, every written byte is acknowledged and appears on rx_data for exactly one cycle of rx_valid. rx_first is 1 for the first such byte after the identity byte and 0 for later ones.
- R6: If tx_mode is high when the block ends one of its own acknowledge slots, the next byte is tx_data, sent MSB first: a 0 bit pulls SDA low and a 1 bit releases it. SDA is then released for the host's acknowledge slot, and the block stays silent until the next start or stop.
- R7: frame_end pulses for one cycle after a stop that closes a transaction whose latest identity byte was acknowledged. Any other stop gives no pulse.
- R8: A start in the middle of a transaction (a repeated start) restarts identity-byte reception, and the next byte counts as the first again.
- R9: A pulse shorter than FILT_LEN system clocks on either line has no effect on the bus behaviour.
- R10: sda_oe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad (resolved level) |
| strap_addr | input | 4 | Strap value that the low nibble of the identity byte must match |
| busy | input | 1 | High while a nonvolatile write is in progress; forces the identity byte to be refused |
| tx_mode | input | 1 | Read request, sampled at the end of each acknowledge slot the block gives |
| tx_data | input | 8 | Byte sent to the host when tx_mode is taken |
| sda_oe | output | 1 | Pulls SDA low when high |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Received byte, valid with rx_valid |
| rx_first | output | 1 | Marks the first byte after the identity byte |
| frame_end | output | 1 | One-cycle strobe after a stop that closes an addressed transaction |

## Verification
A bus edge reaches the byte logic SYNC_STAGES + FILT_LEN + 1 system clocks after it is driven, which is six clocks at the defaults, and sda_oe moves on the clock after that. The bench holds every bus phase for ten clocks. It reads the acknowledge and read-data levels in the middle of SCL high, long after the change is due. The receive and frame-end strobes arrive at a time set by the filter, so they are not matched to a fixed cycle. A scoreboard pairs them in order with the items the driver expected, and a final check confirms that nothing is left over.

// File: rtl/twi_fe_pkg.sv
// Shared constants and state encoding for the two-wire device front end.
// Assumes byte-wide transfers whose first byte is a type code plus strap bits.
package twi_fe_pkg;
    localparam int TWI_BYTE_W  = 8;
    localparam int TWI_TYPE_W  = 4;
    localparam int TWI_STRAP_W = TWI_BYTE_W - TWI_TYPE_W;
    localparam logic [TWI_TYPE_W-1:0] TWI_DEV_TYPE = 4'b0101;

    typedef enum logic [2:0] {
        FE_IDLE   = 3'd0,
        FE_RECV   = 3'd1,
        FE_DECIDE = 3'd2,
        FE_ACK    = 3'd3,
        FE_SEND   = 3'd4
    } fe_state_t;
endpackage

// File: rtl/twi_line_filter.sv
// Synchroniser plus glitch filter for one bus line.
// Assumes SYNC_STAGES >= 2. The output follows the input only after the
// synchronised level has differed from it for FILT_LEN consecutive clocks.
module twi_line_filter #(
    parameter int   SYNC_STAGES = 2,
    parameter int   FILT_LEN    = 3,
    parameter logic RESET_VAL   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       run_cnt;
    logic                   filt_q;

    // Bring the asynchronous pad level into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= {SYNC_STAGES{RESET_VAL}};
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
    end

    // Accept a new level only once it has persisted long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q  <= RESET_VAL;
            run_cnt <= '0;
        end else if (sync_q[SYNC_STAGES-1] != filt_q) begin
            if (run_cnt == CNT_LAST) begin
                filt_q  <= sync_q[SYNC_STAGES-1];
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end else begin
            run_cnt <= '0;
        end
    end

    assign line_out = filt_q;
endmodule

// File: rtl/twi_bus_events.sv
// Turns the filtered SCL and SDA levels into one-cycle bus events:
// SCL rising and falling edges, start and stop conditions.
// Assumes both inputs are already synchronous and glitch free.
module twi_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_q;
    logic sda_q;

    // Remember the previous filtered levels for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // Classify the transition seen this cycle.
    always_comb begin
        scl_rise = scl_f & ~scl_q;
        scl_fall = ~scl_f & scl_q;
        start_ev = scl_f & scl_q & sda_q & ~sda_f;
        stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
    end
endmodule

// File: rtl/twi_byte_engine.sv
// Byte-level state machine: shifts bytes in on SCL rising edges, decides
// and drives acknowledges, hands received bytes downstream, shifts read
// data out, and reports the end of an addressed transaction.
// Assumes single-cycle event inputs from twi_bus_events; SDA is pulled
// low only through sda_oe and changes only after an SCL falling edge.
module twi_byte_engine
    import twi_fe_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_rise,
    input  logic                   scl_fall,
    input  logic                   start_ev,
    input  logic                   stop_ev,
    input  logic                   sda_f,
    input  logic [TWI_STRAP_W-1:0] strap_addr,
    input  logic                   busy,
    input  logic                   tx_mode,
    input  logic [TWI_BYTE_W-1:0]  tx_data,
    output logic                   sda_oe,
    output logic                   rx_valid,
    output logic [TWI_BYTE_W-1:0]  rx_data,
    output logic                   rx_first,
    output logic                   frame_end
);
    localparam int CNT_W = $clog2(TWI_BYTE_W);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(TWI_BYTE_W - 1);

    fe_state_t              state;
    logic [CNT_W-1:0]       bit_cnt;
    logic [TWI_BYTE_W-1:0]  shreg;
    logic                   is_ident;
    logic                   first_pend;
    logic                   selected;
    logic                   ident_hit;

    // Compare a completed identity byte with type code and straps.
    always_comb begin
        ident_hit = (shreg[TWI_BYTE_W-1 -: TWI_TYPE_W] == TWI_DEV_TYPE) &&
                    (shreg[TWI_STRAP_W-1:0] == strap_addr);
    end

    // Main sequencing of bits, acknowledges and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= FE_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            is_ident   <= 1'b0;
            first_pend <= 1'b0;
            selected   <= 1'b0;
            sda_oe     <= 1'b0;
            rx_valid   <= 1'b0;
            rx_data    <= '0;
            rx_first   <= 1'b0;
            frame_end  <= 1'b0;
        end else begin
            rx_valid  <= 1'b0;
            frame_end <= 1'b0;
            if (stop_ev) begin
                state     <= FE_IDLE;
                sda_oe    <= 1'b0;
                frame_end <= selected;
                selected  <= 1'b0;
            end else if (start_ev) begin
                state    <= FE_RECV;
                sda_oe   <= 1'b0;
                bit_cnt  <= '0;
                is_ident <= 1'b1;
                selected <= 1'b0;
            end else begin
                case (state)
                    FE_RECV: begin
                        if (scl_rise) begin
                            shreg <= {shreg[TWI_BYTE_W-2:0], sda_f};
                            if (bit_cnt == BIT_LAST) begin
                                bit_cnt <= '0;
                                state   <= FE_DECIDE;
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    FE_DECIDE: begin
                        if (scl_fall) begin
                            if (is_ident) begin
                                if (ident_hit && !busy) begin
                                    sda_oe     <= 1'b1;
                                    selected   <= 1'b1;
                                    first_pend <= 1'b1;
                                    state      <= FE_ACK;
                                end else begin
                                    state <= FE_IDLE;
                                end
                            end else begin
                                sda_oe     <= 1'b1;
                                rx_valid   <= 1'b1;
                                rx_data    <= shreg;
                                rx_first   <= first_pend;
                                first_pend <= 1'b0;
                                state      <= FE_ACK;
                            end
                        end
                    end
                    FE_ACK: begin
                        if (scl_fall) begin
                            is_ident <= 1'b0;
                            bit_cnt  <= '0;
                            if (tx_mode) begin
                                shreg  <= tx_data;
                                sda_oe <= ~tx_data[TWI_BYTE_W-1];
                                state  <= FE_SEND;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= FE_RECV;
                            end
                        end
                    end
                    FE_SEND: begin
                        if (scl_fall) begin
                            if (bit_cnt == BIT_LAST) begin
                                sda_oe <= 1'b0;
                                state  <= FE_IDLE;
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                                shreg   <= shreg << 1;
                                sda_oe  <= ~shreg[TWI_BYTE_W-2];
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/twi_dev_front.sv
// Top of the two-wire device front end. Filters both bus lines (one filter
// instance per line), derives bus events and runs the byte engine.
// Assumes an external pull-up on SDA; the block only pulls it low.
module twi_dev_front
    import twi_fe_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_in,
    input  logic                   sda_in,
    input  logic [TWI_STRAP_W-1:0] strap_addr,
    input  logic                   busy,
    input  logic                   tx_mode,
    input  logic [TWI_BYTE_W-1:0]  tx_data,
    output logic                   sda_oe,
    output logic                   rx_valid,
    output logic [TWI_BYTE_W-1:0]  rx_data,
    output logic                   rx_first,
    output logic                   frame_end
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] line_raw;
    logic [N_LINES-1:0] line_filt;
    logic scl_filt;
    logic sda_filt;
    logic scl_rise;
    logic scl_fall;
    logic start_ev;
    logic stop_ev;

    assign line_raw = {sda_in, scl_in};

    for (genvar li = 0; li < N_LINES; li++) begin : g_line
        twi_line_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN),
            .RESET_VAL   (1'b1)
        ) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .line_in  (line_raw[li]),
            .line_out (line_filt[li])
        );
    end

    assign scl_filt = line_filt[0];
    assign sda_filt = line_filt[1];

    twi_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (scl_filt),
        .sda_f    (sda_filt),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    twi_byte_engine u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_ev   (start_ev),
        .stop_ev    (stop_ev),
        .sda_f      (sda_filt),
        .strap_addr (strap_addr),
        .busy       (busy),
        .tx_mode    (tx_mode),
        .tx_data    (tx_data),
        .sda_oe     (sda_oe),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_first   (rx_first),
        .frame_end  (frame_end)
    );
endmodule

// File: rtl/twi_fe_checker.sv
// Property checker for twi_dev_front, attached by bind below.
// Observes the output enable, the strobes and the internal bus events.
module twi_fe_checker (
    input logic clk,
    input logic rst_n,
    input logic sda_oe,
    input logic scl_f,
    input logic start_ev,
    input logic stop_ev,
    input logic rx_valid,
    input logic frame_end
);
    // R10: the enable never moves while filtered SCL is high.
    p_oe_moves_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_f);

    // R2: a start or stop leaves SDA released.
    p_release_on_cond_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev || stop_ev) |=> !sda_oe);

    // R5: a received-byte strobe lasts one cycle.
    p_rx_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R7: a frame-end strobe follows a stop condition.
    p_end_after_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> $past(stop_ev));

    // R7: a frame-end strobe lasts one cycle.
    p_end_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end);
endmodule

bind twi_dev_front twi_fe_checker u_fe_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .scl_f     (scl_filt),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .rx_valid  (rx_valid),
    .frame_end (frame_end)
);

// File: tb/twi_dev_front_test.sv
// Scoreboard bench: the bus driver pushes expected strobes into a queue,
// a monitor pops and compares them as the design emits them.
module twi_dev_front_test;
    localparam time CLK_PERIOD = 10ns;
    localparam int  Q = 10;
    localparam logic [3:0] STRAP = 4'b1010;
    localparam logic [7:0] IDENT = {4'b0101, STRAP};

    typedef struct {
        bit         is_end;
        bit         first;
        logic [7:0] data;
        string      req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic busy = 1'b0;
    logic tx_mode = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic sda_bus;
    logic sda_oe, rx_valid, rx_first, frame_end;
    logic [7:0] rx_data;

    int n_cmp = 0;
    int n_bad = 0;
    int oe_hi_moves = 0;
    logic prev_oe = 1'b0;
    logic prev_scl = 1'b1;
    exp_t exp_q[$];

    assign sda_bus = m_sda & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    twi_dev_front uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (m_scl),
        .sda_in     (sda_bus),
        .strap_addr (STRAP),
        .busy       (busy),
        .tx_mode    (tx_mode),
        .tx_data    (tx_data),
        .sda_oe     (sda_oe),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_first   (rx_first),
        .frame_end  (frame_end)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_rx(logic [7:0] d, bit first, string req);
        exp_t it;
        it.is_end = 1'b0; it.first = first; it.data = d; it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic push_end(string req);
        exp_t it;
        it.is_end = 1'b1; it.first = 1'b0; it.data = 8'h00; it.req = req;
        exp_q.push_back(it);
    endtask

    // One SCL period; g=1 adds a 1-clock SDA low pulse in SCL high,
    // g=2 a 1-clock SCL high pulse in SCL low. r is SDA mid-high.
    task automatic bus_bit(logic b, int g, output logic r);
        m_sda = b; wq(Q);
        m_scl = 1'b1;
        if (g == 1) begin wq(3); m_sda = 1'b0; wq(1); m_sda = b; wq(Q-4); end
        else wq(Q);
        r = sda_bus; wq(Q);
        m_scl = 1'b0;
        if (g == 2) begin wq(3); m_scl = 1'b1; wq(1); m_scl = 1'b0; wq(Q-4); end
        else wq(Q);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(Q);
    endtask

    task automatic write_byte(logic [7:0] v, int gbit, int gkind, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bus_bit(v[i], (i == gbit) ? gkind : 0, r);
        bus_bit(1'b1, 0, r);
        ack = ~r;
    endtask

    task automatic read_byte(logic host_ack, output logic [7:0] v, output logic slot);
        logic r;
        for (int i = 7; i >= 0; i--) begin bus_bit(1'b1, 0, r); v[i] = r; end
        bus_bit(~host_ack, 0, r);
        slot = r;
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Monitor: pair design strobes with expected items, and watch R10.
    always @(negedge clk) begin
        exp_t it;
        if (rst_n) begin
            if (rx_valid) begin
                if (exp_q.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R5 unexpected byte actual=%0h expected=none", rx_data);
                end else begin
                    it = exp_q.pop_front();
                    check(it.req, 32'({1'b0, rx_first, rx_data}),
                          32'({it.is_end, it.first, it.data}));
                end
            end
            if (frame_end) begin
                if (exp_q.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R7 unexpected frame_end actual=1 expected=0");
                end else begin
                    it = exp_q.pop_front();
                    check(it.req, 32'({1'b1, 1'b0, 8'h00}),
                          32'({it.is_end, it.first, it.data}));
                end
            end
            if (sda_oe != prev_oe && m_scl && prev_scl) oe_hi_moves++;
        end
        prev_oe  = sda_oe;
        prev_scl = m_scl;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end

    initial begin
        logic ack, slot;
        logic [7:0] v;

        // R1: reset state
        wq(5);
        check("R1 sda_oe", 32'(sda_oe), 0);
        check("R1 rx_valid", 32'(rx_valid), 0);
        check("R1 frame_end", 32'(frame_end), 0);
        rst_n = 1'b1; wq(10);

        // R2: clocking without a start is ignored
        m_scl = 1'b0; wq(Q);
        write_byte(IDENT, -1, 0, ack); check("R2 no ack before start", 32'(ack), 0);
        write_byte(8'h11, -1, 0, ack); check("R2 no ack before start", 32'(ack), 0);
        bus_stop();

        // R3/R5/R7: addressed write of three bytes
        bus_start();
        write_byte(IDENT, -1, 0, ack); check("R3 matching identity", 32'(ack), 1);
        push_rx(8'hB2, 1, "R5 first byte");
        write_byte(8'hB2, -1, 0, ack); check("R5 ack byte 1", 32'(ack), 1);
        push_rx(8'h3C, 0, "R5 second byte");
        write_byte(8'h3C, -1, 0, ack); check("R5 ack byte 2", 32'(ack), 1);
        push_rx(8'hE7, 0, "R5 third byte");
        write_byte(8'hE7, -1, 0, ack); check("R5 ack byte 3", 32'(ack), 1);
        push_end("R7 end after write");
        bus_stop(); wq(Q);

        // R3: wrong type code, then wrong straps
        bus_start();
        write_byte(8'h6A, -1, 0, ack); check("R3 wrong type", 32'(ack), 0);
        write_byte(8'h12, -1, 0, ack); check("R3 later byte ignored", 32'(ack), 0);
        bus_stop();
        bus_start();
        write_byte(8'h5B, -1, 0, ack); check("R3 wrong strap", 32'(ack), 0);
        bus_stop(); wq(Q);

        // R4: polling while busy, then acknowledged once idle
        busy = 1'b1;
        bus_start();
        write_byte(IDENT, -1, 0, ack); check("R4 busy poll 1", 32'(ack), 0);
        bus_stop();
        bus_start();
        write_byte(IDENT, -1, 0, ack); check("R4 busy poll 2", 32'(ack), 0);
        bus_stop();
        busy = 1'b0;
        bus_start();
        write_byte(IDENT, -1, 0, ack); check("R4 ack after busy", 32'(ack), 1);
        push_end("R7 end after poll");
        bus_stop(); wq(Q);

        // R6: read with host NACK, then silence
        bus_start();
        write_byte(IDENT, -1, 0, ack); check("R6 identity", 32'(ack), 1);
        tx_mode = 1'b1; tx_data = 8'h96;
        push_rx(8'h8C, 1, "R6 command byte");
        write_byte(8'h8C, -1, 0, ack); check("R6 command ack", 32'(ack), 1);
        tx_mode = 1'b0;
        read_byte(1'b0, v, slot);
        check("R6 read data", 32'(v), 32'h96);
        check("R6 released in host slot", 32'(slot), 1);
        write_byte(8'h00, -1, 0, ack); check("R6 silent after read", 32'(ack), 0);
        push_end("R7 end after read");
        bus_stop(); wq(Q);

        // R6: second read pattern with host ACK
        bus_start();
        write_byte(IDENT, -1, 0, ack); check("R6 identity 2", 32'(ack), 1);
        tx_mode = 1'b1; tx_data = 8'h01;
        push_rx(8'h8D, 1, "R6 command byte 2");
        write_byte(8'h8D, -1, 0, ack); check("R6 command ack 2", 32'(ack), 1);
        tx_mode = 1'b0;
        read_byte(1'b1, v, slot);
        check("R6 read data 2", 32'(v), 32'h01);
        check("R6 host ack seen", 32'(slot), 0);
        push_end("R7 end after read 2");
        bus_stop(); wq(Q);

        // R8: repeated start restarts identity reception
        bus_start();
        write_byte(IDENT, -1, 0, ack); check("R8 identity", 32'(ack), 1);
        push_rx(8'h47, 1, "R8 byte before restart");
        write_byte(8'h47, -1, 0, ack); check("R8 ack", 32'(ack), 1);
        bus_start();
        write_byte(IDENT, -1, 0, ack); check("R8 identity after restart", 32'(ack), 1);
        push_rx(8'h21, 1, "R8 first flag after restart");
        write_byte(8'h21, -1, 0, ack); check("R8 ack after restart", 32'(ack), 1);
        push_end("R7 end after restart");
        bus_stop(); wq(Q);

        // R8/R7: restart to another device drops selection
        bus_start();
        write_byte(IDENT, -1, 0, ack); check("R8 identity 3", 32'(ack), 1);
        bus_start();
        write_byte(8'h50, -1, 0, ack); check("R8 foreign identity", 32'(ack), 0);
        bus_stop(); wq(Q);

        // R9: short pulses on SDA (in SCL high) and SCL (in SCL low)
        bus_start();
        write_byte(IDENT, 4, 1, ack); check("R9 SDA glitch", 32'(ack), 1);
        push_rx(8'h9F, 1, "R9 SCL glitch byte");
        write_byte(8'h9F, 2, 2, ack); check("R9 SCL glitch ack", 32'(ack), 1);
        push_end("R7 end after glitches");
        bus_stop(); wq(2*Q);

        check("R7 scoreboard drained", 32'(exp_q.size()), 0);
        check("R10 oe moves in SCL high", 32'(oe_hi_moves), 0);
        report();
    end
endmodule